// File: doc/BRIEF.md
# Monotonic Counter Register Bank

The block holds a small bank of 16-bit words that sit at the bottom of a byte-addressed memory space. A word can only be moved upwards: a write that offers a value no larger than the one already stored is discarded. This makes each word usable as a counter that cannot be wound back, for example a usage tally or a remaining-credit count.

A serial front end, which lies outside this block, decodes the update command. When chip select rises it hands this block one summary of the frame in a single cycle: the byte address, the two data bytes (the first byte received becomes the upper byte of the word), and the number of serial clock pulses that were counted during the frame. The block checks the frame and then runs a self-timed write cycle. During that cycle it compares the offered value with the stored one and commits the value only if it is strictly larger. At the end of the cycle it reports the comparison result on a flag and pulses a request that clears the write-enable latch.

A byte read port lets the read engine fetch any byte of the bank at any time. The bank has no protection inputs. The comparison is the only gate on an update, so no write-protect pin or block-protect setting affects it.

Top module: `mono_counter_bank`

## Requirements
- R1: After reset every word reads 0000h, `busy` is 0, `cmp_flag` is 0 and `wel_clr` is 0.
- R2: `rd_data` combinationally returns one byte of the bank. Bits `rd_addr[4:1]` select the word. `rd_addr[0]`=0 returns the upper byte and `rd_addr[0]`=1 returns the lower byte.
- R3: A frame is taken only if all of the following hold: `wel_in`=1, `frm_clks` equals 40, `frm_addr[0]`=0, and `frm_addr` is below 32. The frame data is committed only if it is strictly greater than the stored word. A stored word never decreases.
- R4: When a taken frame ends, `cmp_flag` becomes 1 if the offered value was lower than or equal to the stored word, and 0 if it was higher. An equal or lower offer leaves the word unchanged.
- R5: A frame whose clock count is not exactly 40 (for example 39 or 41) starts no cycle and changes neither the words nor `cmp_flag`.
- R6: A frame with an odd address, or with an address of 32 or above, starts no cycle and changes nothing.
- R7: A frame presented while `wel_in` is 0 starts no cycle and changes nothing.
- R8: `busy` rises on the edge that samples a taken frame and stays high for exactly 8 clock cycles. A rejected or equal offer still runs the full cycle. The word and `cmp_flag` change only on the edge where `busy` falls.
- R9: `wel_clr` is high for exactly the one cycle that follows the edge where `busy` falls, and is low at all other times.
- R10: A frame presented while `busy` is 1 is ignored and leaves every word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset; clears the bank |
| frm_valid | input | 1 | One-cycle pulse: a decoded update frame has ended |
| frm_addr | input | 10 | Byte address carried by the frame |
| frm_data | input | 16 | Offered word; the first byte received is bits 15:8 |
| frm_clks | input | 8 | Serial clock pulses counted during the frame |
| wel_in | input | 1 | Write-enable latch state |
| rd_addr | input | 5 | Byte address for reads |
| rd_data | output | 8 | Byte read from the bank |
| busy | output | 1 | Self-timed write cycle in progress |
| cmp_flag | output | 1 | 1 if the last offered value was not higher than the stored word |
| wel_clr | output | 1 | One-cycle request to clear the write-enable latch |

## Verification
The frame input is driven on a falling edge and is sampled on the next rising edge. `busy` can therefore first be seen at the falling edge after that. The bench then counts falling edges while `busy` stays high and expects exactly 8. On the first falling edge where `busy` is low, it checks `wel_clr`, `cmp_flag` and the word bytes, all of which are due on the edge where `busy` fell. For frames that must be ignored, the bench checks `busy` one falling edge after the sampling edge. It then checks the flag and the bytes a few cycles later through the read port. Reads are combinational and are sampled a short delay after the address is set.

// File: rtl/mono_counter_bank.sv
module mono_counter_bank #(
  parameter int NUM_WORDS    = 16,
  parameter int ADDR_W       = 10,
  parameter int FRAME_CLKS   = 40,
  parameter int CLKCNT_W     = 8,
  parameter int WRITE_CYCLES = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         frm_valid,
  input  logic [ADDR_W-1:0]            frm_addr,
  input  logic [15:0]                  frm_data,
  input  logic [CLKCNT_W-1:0]          frm_clks,
  input  logic                         wel_in,
  input  logic [$clog2(NUM_WORDS):0]   rd_addr,
  output logic [7:0]                   rd_data,
  output logic                         busy,
  output logic                         cmp_flag,
  output logic                         wel_clr
);
  localparam int IDX_W = $clog2(NUM_WORDS);
  localparam int CNT_W = $clog2(WRITE_CYCLES + 1);

  logic [15:0]      mem [NUM_WORDS];
  logic [IDX_W-1:0] p_idx;
  logic [15:0]      p_val;
  logic [CNT_W-1:0] cnt;

  wire in_range = frm_addr < ADDR_W'(2 * NUM_WORDS);
  wire frame_ok = frm_valid && !busy && wel_in && !frm_addr[0] && in_range &&
                  (frm_clks == CLKCNT_W'(FRAME_CLKS));
  wire done     = busy && (cnt == '0);
  wire higher   = p_val > mem[p_idx];

  wire [15:0] rd_word = mem[rd_addr[IDX_W:1]];
  assign rd_data = rd_addr[0] ? rd_word[7:0] : rd_word[15:8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cnt      <= '0;
      cmp_flag <= 1'b0;
      wel_clr  <= 1'b0;
      p_idx    <= '0;
      p_val    <= '0;
      for (int i = 0; i < NUM_WORDS; i++) mem[i] <= '0;
    end else begin
      wel_clr <= done;
      if (frame_ok) begin
        busy  <= 1'b1;
        cnt   <= CNT_W'(WRITE_CYCLES - 1);
        p_idx <= frm_addr[IDX_W:1];
        p_val <= frm_data;
      end else if (done) begin
        busy     <= 1'b0;
        cmp_flag <= !higher;
        if (higher) mem[p_idx] <= p_val;
      end else if (busy) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word_chk
    a_r3_never_decreases: assert property (@(posedge clk) disable iff (!rst_n)
      mem[g] >= $past(mem[g]));
    a_r8_word_moves_at_end: assert property (@(posedge clk) disable iff (!rst_n)
      (mem[g] != $past(mem[g])) |-> $fell(busy));
  end

  a_r4_flag_moves_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_flag != $past(cmp_flag)) |-> $fell(busy));

  a_r9_clear_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wel_clr |-> $fell(busy));

  a_r7_start_needs_latch: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(frm_valid && wel_in));

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wel_clr |=> !wel_clr);
endmodule

// File: tb/tb_mono_counter_bank.sv
module tb_mono_counter_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frm_valid = 1'b0;
  logic [9:0]  frm_addr = '0;
  logic [15:0] frm_data = '0;
  logic [7:0]  frm_clks = '0;
  logic        wel_in = 1'b0;
  logic [4:0]  rd_addr = '0;
  logic [7:0]  rd_data;
  logic        busy, cmp_flag, wel_clr;

  int checks = 0;
  int fails  = 0;
  logic [15:0] model [16];

  always #4 clk = ~clk;

  mono_counter_bank dut (
    .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_addr(frm_addr),
    .frm_data(frm_data), .frm_clks(frm_clks), .wel_in(wel_in),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy),
    .cmp_flag(cmp_flag), .wel_clr(wel_clr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_bank(input string req);
    bit ok = 1'b1;
    int bad_act = 0, bad_exp = 0;
    for (int b = 0; b < 32; b++) begin
      logic [7:0] e;
      rd_addr = 5'(b);
      #1;
      e = b[0] ? model[b/2][7:0] : model[b/2][15:8];
      if (ok && rd_data !== e) begin
        ok = 1'b0; bad_act = rd_data; bad_exp = e;
      end
    end
    chk(ok, req, bad_act, bad_exp);
  endtask

  task automatic drive(input logic [9:0] a, input logic [15:0] d, input logic [7:0] n);
    frm_addr = a; frm_data = d; frm_clks = n; frm_valid = 1'b1;
    @(negedge clk);
    frm_valid = 1'b0;
  endtask

  task automatic good_write(input int w, input logic [15:0] d, input string req);
    int nb = 0;
    logic exp_flag;
    wel_in = 1'b1;
    exp_flag = !(d > model[w]);
    if (d > model[w]) model[w] = d;
    @(negedge clk);
    drive(10'(w * 2), d, 8'd40);
    while (busy && nb < 50) begin
      nb++;
      @(negedge clk);
    end
    chk(nb == 8, "R8 busy length", nb, 8);
    chk(wel_clr == 1'b1, "R9 clear pulse", wel_clr, 1);
    chk(cmp_flag == exp_flag, req, cmp_flag, exp_flag);
    @(negedge clk);
    chk(wel_clr == 1'b0, "R9 pulse ends", wel_clr, 0);
    chk_bank(req);
  endtask

  task automatic ignored(input logic [9:0] a, input logic [15:0] d, input logic [7:0] n,
                         input logic we, input string req);
    logic fl;
    fl = cmp_flag;
    wel_in = we;
    @(negedge clk);
    drive(a, d, n);
    chk(busy == 1'b0, req, busy, 0);
    repeat (10) @(negedge clk);
    chk(cmp_flag == fl && wel_clr == 1'b0, req, cmp_flag, fl);
    chk_bank(req);
    wel_in = 1'b1;
  endtask

  task automatic overlap_test();
    int nb = 0;
    wel_in = 1'b1;
    @(negedge clk);
    drive(10'd0, 16'h0005, 8'd40);
    repeat (2) @(negedge clk);
    drive(10'd2, 16'h0009, 8'd40);
    while (busy && nb < 50) begin
      nb++;
      @(negedge clk);
    end
    model[0] = 16'h0005;
    repeat (12) @(negedge clk);
    chk(busy == 1'b0, "R10 no second cycle", busy, 0);
    chk_bank("R10 frame during busy ignored");
  endtask

  initial begin
    for (int i = 0; i < 16; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    chk(busy == 0 && cmp_flag == 0 && wel_clr == 0, "R1 reset outputs", {busy, cmp_flag, wel_clr}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_bank("R1 reset words");
    good_write(3, 16'h1234, "R3 higher commits");
    rd_addr = 5'd6; #1;
    chk(rd_data == 8'h12, "R2 upper byte", rd_data, 8'h12);
    rd_addr = 5'd7; #1;
    chk(rd_data == 8'h34, "R2 lower byte", rd_data, 8'h34);
    good_write(3, 16'h1234, "R4 equal rejected");
    good_write(3, 16'h1000, "R4 lower rejected");
    good_write(3, 16'h1235, "R4 higher clears flag");
    ignored(10'd8, 16'h7777, 8'd39, 1'b1, "R5 short frame");
    ignored(10'd8, 16'h7777, 8'd41, 1'b1, "R5 long frame");
    ignored(10'd7, 16'h7777, 8'd40, 1'b1, "R6 odd address");
    ignored(10'd32, 16'h7777, 8'd40, 1'b1, "R6 out of range");
    ignored(10'd8, 16'h7777, 8'd40, 1'b0, "R7 latch clear");
    overlap_test();
    good_write(15, 16'hFFFF, "R3 top word max");
    good_write(15, 16'hFFFF, "R4 max equal rejected");
    good_write(0, 16'h0004, "R4 lower than five");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    fails++;
    checks++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule